// File: doc/BRIEF.md
# AGC loop gain accumulator

This block performs the update step of a first-order automatic gain control loop. On each valid output sample it reads an unsigned magnitude and subtracts it from a programmable threshold. The result is a signed gain error. The error is scaled by a loop gain made of a 4-bit mantissa and a 4-bit exponent, and the scaled error is added into a gain accumulator. The accumulator is clamped between programmable upper and lower limits, and its integer part drives the gain-control output.

All settings are written into master registers. The loop uses working copies of these settings, so a write never reaches a loop that is part-way through an update until a load strobe is given. When the sync enable is set, an external sync pulse also copies the master settings into the working registers and restarts the accumulator at the programmed initial gain. This lets several loops start together from the same gain. A select input chooses between two loop-gain pairs, typically a fast acquisition gain and a slow tracking gain.

Magnitude and threshold share one fixed-point scale, with the LSB worth 2^-10 and the MSB worth 2^2. The integer part of the accumulator (`gain_out`) counts in that same LSB. Below it sit `GUARD` fractional bits, which keep small steps from being lost.

Top module: `agc_loop_update`

## Requirements
- R1: Synchronous reset sets `gain_out` to 0 (the default initial gain). It also resets the master and working registers: threshold 0, both loop-gain pairs 0 (step zero), upper limit 32767, lower limit -32768, initial gain 0, sync enable off.
- R2: The gain error is the working threshold minus `mag`, both taken as unsigned 13-bit values, giving a signed 14-bit result.
- R3: The step added per sample is floor(err * M * 2^GUARD / 2^(4 + 15 - E)), in accumulator units with GUARD = 8 fractional bits. M is the 4-bit mantissa and E is the 4-bit exponent. The shift is arithmetic, so a negative error always gives a step that is zero or negative.
- R4: When `gain_sel` = 0 the loop gain comes from pair A (register 1). When `gain_sel` = 1 it comes from pair B (register 2). In both registers bits [3:0] hold the mantissa and bits [7:4] hold the exponent.
- R5: The accumulator changes only on a clock edge where `sample_vld` = 1, or on reset or an accepted sync. Otherwise `gain_out` holds its value whatever `mag` does.
- R6: The sum of the accumulator and the step is clamped to the working upper limit (checked first) and then to the working lower limit. The accumulator never wraps.
- R7: `cfg_wr` writes only the master register selected by `cfg_addr`. The address map is: 0 threshold [12:0], 1 pair A, 2 pair B, 3 upper limit, 4 lower limit, 5 initial gain (the three gain values are signed 16-bit), and 6 control, where bit 0 is the sync enable. The working registers take the master values only on the edge where `cfg_load` = 1 or a sync is accepted.
- R8: When the master sync enable is 1, an edge with `ext_sync` = 1 loads the accumulator with the master initial gain (fraction zero) and copies master to working. When the sync enable is 0, `ext_sync` has no effect.
- R9: Priority is reset, then an accepted sync, then a sample update. A sync and a sample on the same edge leave the accumulator at the initial gain.
- R10: `gain_out` is the signed integer part of the accumulator: accumulator bits [GAIN_W+GUARD-1:GUARD].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr | input | 1 | Master register write strobe |
| cfg_addr | input | 3 | Master register address |
| cfg_wdata | input | DATA_W (16) | Master register write data |
| cfg_load | input | 1 | Copy master registers to working registers |
| ext_sync | input | 1 | External sync pulse |
| sample_vld | input | 1 | Magnitude sample valid; enables an accumulator update |
| mag | input | THR_W (13) | Unsigned magnitude sample |
| gain_sel | input | 1 | Loop-gain pair select (0 = A, 1 = B) |
| gain_out | output | GAIN_W (16) | Signed integer part of the gain accumulator |

## Verification
A bad working copy or a wrong gain-pair select shows up in `gain_out` on the first sample after it. A wrong shift amount or a lost sign shows up on the same edge as the bad step, provided the step is larger than one output LSB. Errors in the guard bits stay hidden in the fractional part until several samples have built up, so the sweep checks a running accumulator over hundreds of samples and never resets it between them. Saturation faults show only when a limit is crossed, so limits are pushed from both sides.

// File: rtl/agc_pkg.sv
package agc_pkg;

   localparam int AGC_MANT_W = 4;
   localparam int AGC_EXP_W  = 4;
   localparam int AGC_ADDR_W = 3;

   typedef enum logic [AGC_ADDR_W-1:0] {
      AGC_REG_THRESH = 3'd0,
      AGC_REG_PAIR_A = 3'd1,
      AGC_REG_PAIR_B = 3'd2,
      AGC_REG_LIM_HI = 3'd3,
      AGC_REG_LIM_LO = 3'd4,
      AGC_REG_INIT   = 3'd5,
      AGC_REG_CTRL   = 3'd6
   } agc_reg_e;

   typedef struct packed {
      logic [AGC_EXP_W-1:0]  expo;
      logic [AGC_MANT_W-1:0] mant;
   } agc_lgain_t;

endpackage

// File: rtl/agc_cfg_regs.sv
module agc_cfg_regs
   import agc_pkg::*;
#(
   parameter int THR_W      = 13,
   parameter int GAIN_W     = 16,
   parameter int DATA_W     = 16,
   parameter int THR_DEF    = 0,
   parameter int INIT_DEF   = 0,
   parameter int LIM_HI_DEF = 32767,
   parameter int LIM_LO_DEF = -32768
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     cfg_wr,
   input  logic [AGC_ADDR_W-1:0]    cfg_addr,
   input  logic [DATA_W-1:0]        cfg_wdata,
   input  logic                     cfg_load,
   input  logic                     ext_sync,
   output logic                     sync_take,
   output logic [THR_W-1:0]         wk_thr,
   output agc_lgain_t               wk_pair_a,
   output agc_lgain_t               wk_pair_b,
   output logic signed [GAIN_W-1:0] wk_lim_hi,
   output logic signed [GAIN_W-1:0] wk_lim_lo,
   output logic signed [GAIN_W-1:0] ms_init
);

   localparam int LG_W = AGC_MANT_W + AGC_EXP_W;
   localparam logic [THR_W-1:0]         THR_D = THR_W'(THR_DEF);
   localparam logic signed [GAIN_W-1:0] HI_D  = GAIN_W'(LIM_HI_DEF);
   localparam logic signed [GAIN_W-1:0] LO_D  = GAIN_W'(LIM_LO_DEF);
   localparam logic signed [GAIN_W-1:0] INI_D = GAIN_W'(INIT_DEF);

   logic [THR_W-1:0]         ms_thr;
   agc_lgain_t               ms_pair_a;
   agc_lgain_t               ms_pair_b;
   logic signed [GAIN_W-1:0] ms_lim_hi;
   logic signed [GAIN_W-1:0] ms_lim_lo;
   logic                     ms_sync_en;
   logic                     copy_en;

   always_ff @(posedge clk) begin
      if (rst) begin
         ms_thr     <= THR_D;
         ms_pair_a  <= '0;
         ms_pair_b  <= '0;
         ms_lim_hi  <= HI_D;
         ms_lim_lo  <= LO_D;
         ms_init    <= INI_D;
         ms_sync_en <= 1'b0;
      end else if (cfg_wr) begin
         case (agc_reg_e'(cfg_addr))
            AGC_REG_THRESH: ms_thr     <= cfg_wdata[THR_W-1:0];
            AGC_REG_PAIR_A: ms_pair_a  <= agc_lgain_t'(cfg_wdata[LG_W-1:0]);
            AGC_REG_PAIR_B: ms_pair_b  <= agc_lgain_t'(cfg_wdata[LG_W-1:0]);
            AGC_REG_LIM_HI: ms_lim_hi  <= cfg_wdata[GAIN_W-1:0];
            AGC_REG_LIM_LO: ms_lim_lo  <= cfg_wdata[GAIN_W-1:0];
            AGC_REG_INIT:   ms_init    <= cfg_wdata[GAIN_W-1:0];
            AGC_REG_CTRL:   ms_sync_en <= cfg_wdata[0];
            default: ;
         endcase
      end
   end

   assign sync_take = ext_sync & ms_sync_en;
   assign copy_en   = cfg_load | sync_take;

   always_ff @(posedge clk) begin
      if (rst) begin
         wk_thr    <= THR_D;
         wk_pair_a <= '0;
         wk_pair_b <= '0;
         wk_lim_hi <= HI_D;
         wk_lim_lo <= LO_D;
      end else if (copy_en) begin
         wk_thr    <= ms_thr;
         wk_pair_a <= ms_pair_a;
         wk_pair_b <= ms_pair_b;
         wk_lim_hi <= ms_lim_hi;
         wk_lim_lo <= ms_lim_lo;
      end
   end

   AST_WORKING_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (!cfg_load && !ext_sync) |=> ($stable(wk_thr) && $stable(wk_pair_a) && $stable(wk_pair_b)
                                    && $stable(wk_lim_hi) && $stable(wk_lim_lo))); // R7
   AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (rst)
      cfg_load |=> (wk_thr == $past(ms_thr) && wk_lim_hi == $past(ms_lim_hi))); // R7

endmodule

// File: rtl/agc_step_calc.sv
module agc_step_calc
   import agc_pkg::*;
#(
   parameter int THR_W      = 13,
   parameter int GUARD      = 8,
   parameter int SHIFT_IMPL = 1,
   parameter int STEP_W     = THR_W + 2 + AGC_MANT_W + GUARD
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic [THR_W-1:0]         thr,
   input  logic [THR_W-1:0]         mag,
   input  agc_lgain_t               lg,
   output logic signed [THR_W:0]    err,
   output logic signed [STEP_W-1:0] step
);

   localparam int PROD_W = THR_W + 2 + AGC_MANT_W;
   localparam int SH_MAX = AGC_MANT_W + (2 ** AGC_EXP_W) - 1;
   localparam int SH_W   = $clog2(SH_MAX + 1);

   logic signed [PROD_W-1:0] prod;
   logic signed [STEP_W-1:0] scaled;
   logic [SH_W-1:0]          sh;

   assign err    = $signed({1'b0, thr}) - $signed({1'b0, mag});
   assign prod   = err * $signed({1'b0, lg.mant});
   assign scaled = {prod, {GUARD{1'b0}}};
   assign sh     = SH_W'(SH_MAX) - SH_W'(lg.expo);

   generate
      if (SHIFT_IMPL == 0) begin : g_shift_op
         assign step = scaled >>> sh;
      end else begin : g_shift_barrel
         logic signed [STEP_W-1:0] stg [SH_W+1];
         assign stg[0] = scaled;
         for (genvar k = 0; k < SH_W; k++) begin : g_stage
            assign stg[k+1] = sh[k] ? (stg[k] >>> (1 << k)) : stg[k];
         end
         assign step = stg[SH_W];
      end
   endgenerate

   AST_STEP_SIGN_NEG: assert property (@(posedge clk) disable iff (rst)
      (err < 0) |-> (step <= 0)); // R3
   AST_STEP_SIGN_POS: assert property (@(posedge clk) disable iff (rst)
      (err >= 0) |-> (step >= 0)); // R3
   AST_ZERO_MANT: assert property (@(posedge clk) disable iff (rst)
      (lg.mant == '0) |-> (step == 0)); // R3

endmodule

// File: rtl/agc_gain_acc.sv
module agc_gain_acc #(
   parameter int GAIN_W   = 16,
   parameter int GUARD    = 8,
   parameter int STEP_W   = 27,
   parameter int INIT_DEF = 0
) (
   input  logic                            clk,
   input  logic                            rst,
   input  logic                            sample_vld,
   input  logic                            sync_take,
   input  logic signed [GAIN_W-1:0]        init_gain,
   input  logic signed [STEP_W-1:0]        step,
   input  logic signed [GAIN_W-1:0]        lim_hi,
   input  logic signed [GAIN_W-1:0]        lim_lo,
   output logic signed [GAIN_W+GUARD-1:0]  acc_q
);

   localparam int ACC_W = GAIN_W + GUARD;
   localparam int SUM_W = ((ACC_W > STEP_W) ? ACC_W : STEP_W) + 1;
   localparam logic signed [GAIN_W-1:0] INI_D = GAIN_W'(INIT_DEF);

   logic signed [ACC_W-1:0] hi_full;
   logic signed [ACC_W-1:0] lo_full;
   logic signed [SUM_W-1:0] acc_x;
   logic signed [SUM_W-1:0] step_x;
   logic signed [SUM_W-1:0] hi_x;
   logic signed [SUM_W-1:0] lo_x;
   logic signed [SUM_W-1:0] sum;
   logic signed [ACC_W-1:0] acc_d;

   assign hi_full = {lim_hi, {GUARD{1'b0}}};
   assign lo_full = {lim_lo, {GUARD{1'b0}}};
   assign acc_x   = {{(SUM_W-ACC_W){acc_q[ACC_W-1]}}, acc_q};
   assign step_x  = {{(SUM_W-STEP_W){step[STEP_W-1]}}, step};
   assign hi_x    = {{(SUM_W-ACC_W){hi_full[ACC_W-1]}}, hi_full};
   assign lo_x    = {{(SUM_W-ACC_W){lo_full[ACC_W-1]}}, lo_full};
   assign sum     = acc_x + step_x;

   always_comb begin
      if (sum > hi_x)      acc_d = hi_full;
      else if (sum < lo_x) acc_d = lo_full;
      else                 acc_d = sum[ACC_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (rst)             acc_q <= {INI_D, {GUARD{1'b0}}};
      else if (sync_take)  acc_q <= {init_gain, {GUARD{1'b0}}};
      else if (sample_vld) acc_q <= acc_d;
   end

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
      (!sample_vld && !sync_take) |=> $stable(acc_q)); // R5
   AST_SYNC_LOAD: assert property (@(posedge clk) disable iff (rst)
      sync_take |=> (acc_q[ACC_W-1:GUARD] == $past(init_gain) && acc_q[GUARD-1:0] == '0)); // R8
   AST_WITHIN_LIMITS: assert property (@(posedge clk) disable iff (rst)
      (sample_vld && !sync_take && lim_lo <= lim_hi)
         |=> (acc_q <= $past(hi_full) && acc_q >= $past(lo_full))); // R6
   AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
      (sample_vld && !sync_take && step > 0)
         |=> (acc_q >= $past(acc_q) || acc_q == $past(hi_full))); // R6

endmodule

// File: rtl/agc_loop_update.sv
module agc_loop_update
   import agc_pkg::*;
#(
   parameter int THR_W      = 13,
   parameter int GAIN_W     = 16,
   parameter int GUARD      = 8,
   parameter int DATA_W     = 16,
   parameter int SHIFT_IMPL = 1,
   parameter int THR_DEF    = 0,
   parameter int INIT_DEF   = 0,
   parameter int LIM_HI_DEF = 32767,
   parameter int LIM_LO_DEF = -32768
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cfg_wr,
   input  logic [2:0]        cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic              cfg_load,
   input  logic              ext_sync,
   input  logic              sample_vld,
   input  logic [THR_W-1:0]  mag,
   input  logic              gain_sel,
   output logic [GAIN_W-1:0] gain_out
);

   localparam int ACC_W  = GAIN_W + GUARD;
   localparam int STEP_W = THR_W + 2 + AGC_MANT_W + GUARD;

   generate
      if (GUARD < 8) begin : g_bad_guard
         $error("GUARD must be at least 8 fractional bits");
      end
      if (DATA_W < GAIN_W || DATA_W < THR_W || DATA_W < AGC_MANT_W + AGC_EXP_W) begin : g_bad_data
         $error("DATA_W too narrow for the register fields");
      end
      if (SHIFT_IMPL != 0 && SHIFT_IMPL != 1) begin : g_bad_impl
         $error("SHIFT_IMPL must be 0 or 1");
      end
   endgenerate

   logic                     sync_take;
   logic [THR_W-1:0]         wk_thr;
   agc_lgain_t               wk_pair_a;
   agc_lgain_t               wk_pair_b;
   agc_lgain_t               lg_sel;
   logic signed [GAIN_W-1:0] wk_lim_hi;
   logic signed [GAIN_W-1:0] wk_lim_lo;
   logic signed [GAIN_W-1:0] ms_init;
   logic signed [THR_W:0]    err;
   logic signed [STEP_W-1:0] step;
   logic signed [ACC_W-1:0]  acc_q;

   agc_cfg_regs #(
      .THR_W(THR_W), .GAIN_W(GAIN_W), .DATA_W(DATA_W), .THR_DEF(THR_DEF),
      .INIT_DEF(INIT_DEF), .LIM_HI_DEF(LIM_HI_DEF), .LIM_LO_DEF(LIM_LO_DEF)
   ) i_cfg (
      .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .cfg_load(cfg_load), .ext_sync(ext_sync), .sync_take(sync_take), .wk_thr(wk_thr),
      .wk_pair_a(wk_pair_a), .wk_pair_b(wk_pair_b), .wk_lim_hi(wk_lim_hi),
      .wk_lim_lo(wk_lim_lo), .ms_init(ms_init)
   );

   assign lg_sel = gain_sel ? wk_pair_b : wk_pair_a;

   agc_step_calc #(
      .THR_W(THR_W), .GUARD(GUARD), .SHIFT_IMPL(SHIFT_IMPL), .STEP_W(STEP_W)
   ) i_step (
      .clk(clk), .rst(rst), .thr(wk_thr), .mag(mag), .lg(lg_sel), .err(err), .step(step)
   );

   agc_gain_acc #(
      .GAIN_W(GAIN_W), .GUARD(GUARD), .STEP_W(STEP_W), .INIT_DEF(INIT_DEF)
   ) i_acc (
      .clk(clk), .rst(rst), .sample_vld(sample_vld), .sync_take(sync_take),
      .init_gain(ms_init), .step(step), .lim_hi(wk_lim_hi), .lim_lo(wk_lim_lo), .acc_q(acc_q)
   );

   assign gain_out = acc_q[ACC_W-1:GUARD];

   AST_ERR_RANGE: assert property (@(posedge clk) disable iff (rst)
      (err <= $signed({1'b0, wk_thr}))); // R2
   AST_SYNC_IGNORED: assert property (@(posedge clk) disable iff (rst)
      (!sync_take && !sample_vld) |=> $stable(gain_out)); // R8

endmodule

// File: tb/test_agc_loop_update.sv
`timescale 1ns/1ps
module test_agc_loop_update;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cfg_wr = 1'b0;
   logic [2:0]  cfg_addr = '0;
   logic [15:0] cfg_wdata = '0;
   logic        cfg_load = 1'b0;
   logic        ext_sync = 1'b0;
   logic        sample_vld = 1'b0;
   logic [12:0] mag = '0;
   logic        gain_sel = 1'b0;
   logic [15:0] gain_out;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // bench model: master (m_) and working (w_) copies, accumulator in 1/256 units
   longint m_thr, m_am, m_ae, m_bm, m_be, m_hi, m_lo, m_init;
   bit     m_sen;
   longint w_thr, w_am, w_ae, w_bm, w_be, w_hi, w_lo;
   longint acc;

   always #2 clk = ~clk;

   agc_loop_update i_agc_loop_update (
      .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .cfg_load(cfg_load), .ext_sync(ext_sync), .sample_vld(sample_vld), .mag(mag),
      .gain_sel(gain_sel), .gain_out(gain_out)
   );

   task automatic model_reset();
      m_thr = 0; m_am = 0; m_ae = 0; m_bm = 0; m_be = 0;
      m_hi = 32767; m_lo = -32768; m_init = 0; m_sen = 0;
      w_thr = 0; w_am = 0; w_ae = 0; w_bm = 0; w_be = 0;
      w_hi = 32767; w_lo = -32768; acc = 0;
   endtask

   task automatic copy_working();
      w_thr = m_thr; w_am = m_am; w_ae = m_ae; w_bm = m_bm; w_be = m_be;
      w_hi = m_hi; w_lo = m_lo;
   endtask

   task automatic chk(string req, longint act, longint expv);
      n_chk++;
      if (act != expv) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, expv);
      end
   endtask

   function automatic longint gout();
      return longint'($signed(gain_out));
   endfunction

   task automatic wr(int addr, longint data);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_addr = 3'(addr); cfg_wdata = 16'(data);
      @(negedge clk);
      cfg_wr = 1'b0;
      case (addr)
         0: m_thr = data & 8191;
         1: begin m_am = data & 15; m_ae = (data >> 4) & 15; end
         2: begin m_bm = data & 15; m_be = (data >> 4) & 15; end
         3: m_hi = data;
         4: m_lo = data;
         5: m_init = data;
         6: m_sen = data[0];
         default: ;
      endcase
   endtask

   task automatic load();
      @(negedge clk); cfg_load = 1'b1;
      @(negedge clk); cfg_load = 1'b0;
      copy_working();
   endtask

   task automatic model_sample(longint mg, bit sel);
      longint err, mm, ee, stp, sum;
      err = w_thr - mg;
      mm  = sel ? w_bm : w_am;
      ee  = sel ? w_be : w_ae;
      stp = (err * mm * 256) >>> (19 - ee);
      sum = acc + stp;
      if (sum > w_hi * 256)      acc = w_hi * 256;
      else if (sum < w_lo * 256) acc = w_lo * 256;
      else                       acc = sum;
   endtask

   task automatic sample(string req, longint mg, bit sel);
      @(negedge clk);
      sample_vld = 1'b1; mag = 13'(mg); gain_sel = sel;
      @(negedge clk);
      sample_vld = 1'b0;
      model_sample(mg, sel);
      chk(req, gout(), acc >>> 8);
   endtask

   task automatic sync_pulse(string req, bit with_vld, longint mg);
      @(negedge clk);
      ext_sync = 1'b1; sample_vld = with_vld; mag = 13'(mg);
      @(negedge clk);
      ext_sync = 1'b0; sample_vld = 1'b0;
      if (m_sen) begin acc = m_init * 256; copy_working(); end
      else if (with_vld) model_sample(mg, gain_sel);
      chk(req, gout(), acc >>> 8);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 reset gain", gout(), 0);
      // R1: default pairs give zero step
      sample("R1 default zero step", 100, 1'b0);
      sample("R1 default zero step B", 8191, 1'b1);

      wr(6, 1); wr(5, 0); wr(0, 1000); wr(1, 16'h00F8); load();
      // R2: error = thr - mag, mantissa 8, exponent 15
      for (int i = 0; i < 4; i++) begin
         longint mg;
         mg = (i == 0) ? 0 : (i == 1) ? 1000 : (i == 2) ? 2000 : 8191;
         sync_pulse("R8 sync restart", 1'b0, 0);
         sample("R2 error sign and size", mg, 1'b0);
      end

      // R3/R4: sweep every mantissa/exponent pair, both selects, running accumulator
      wr(0, 3000);
      for (int e = 0; e < 16; e++) begin
         for (int m = 0; m < 16; m++) begin
            wr(1, (e << 4) | m);
            wr(2, ((15 - e) << 4) | (15 - m));
            load();
            sample("R3 step pair A", 0, 1'b0);
            sample("R4 step pair B", 37, 1'b1);
            sample("R3 step pair A neg", 4000, 1'b0);
            sample("R4 step pair B neg", 8191, 1'b1);
            sample("R3 fraction carry", 2999, 1'b0);
         end
      end

      // R5: no valid, magnitude toggling
      begin
         longint hold;
         hold = gout();
         for (int i = 0; i < 8; i++) begin
            @(negedge clk); mag = 13'(i * 1000); gain_sel = i[0];
         end
         @(negedge clk);
         chk("R5 hold without valid", gout(), hold);
      end

      // R7: master write without load is not used
      wr(1, 16'h00FF); load();
      sync_pulse("R8 restart", 1'b0, 0);
      wr(0, 8000);
      sample("R7 old working threshold", 0, 1'b0);
      wr(1, 16'h0000);
      sample("R7 old working pair", 0, 1'b0);
      load();
      sample("R7 loaded pair zero", 0, 1'b0);
      wr(1, 16'h00FF); load();
      sample("R7 loaded threshold", 100, 1'b0);

      // R6: limits from both sides
      wr(3, 100); wr(4, -50); wr(0, 8191); load();
      sync_pulse("R8 restart", 1'b0, 0);
      for (int i = 0; i < 4; i++) sample("R6 upper clamp", 0, 1'b0);
      chk("R6 upper limit value", gout(), 100);
      wr(0, 0); load();
      for (int i = 0; i < 4; i++) sample("R6 lower clamp", 8191, 1'b0);
      chk("R6 lower limit value", gout(), -50);
      wr(3, 32767); wr(4, -32768); wr(0, 8191); load();
      for (int i = 0; i < 12; i++) sample("R6 full scale no wrap", 0, 1'b0);
      chk("R6 top of range", gout(), 32767);

      // R8: sync ignored while disabled, then honoured
      wr(6, 0); wr(5, 77);
      sync_pulse("R8 sync ignored", 1'b0, 0);
      chk("R8 still at limit", gout(), 32767);
      wr(6, 1);
      sync_pulse("R8 sync loads init", 1'b0, 0);
      chk("R8 init value", gout(), 77);
      wr(5, -300);
      // R9: sync beats sample
      sync_pulse("R9 sync over sample", 1'b1, 0);
      chk("R9 init after tie", gout(), -300);
      // R9/R10: reset beats sync
      @(negedge clk); rst = 1'b1; ext_sync = 1'b1;
      @(negedge clk); rst = 1'b0; ext_sync = 1'b0;
      model_reset();
      chk("R9 reset over sync", gout(), 0);
      sample("R10 integer part after reset", 0, 1'b0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule